// File: doc/BRIEF.md
# Single-Wire Command Frame Transmitter

This block sits on the host side of a one-wire control link and turns short commands into the exact line waveforms that a remote receiver expects. A command can wake the receiver with a long high level, shut it down with a long low level, or write one byte into one of 32 receiver registers. A write goes out as a self-timed frame. It starts with a wake pulse and a calibration pulse so that the receiver can measure the bit rate. A low start bit follows, then the address and data bits with the most significant bit first, and last a high standby gap.

The bit time is a count of system clocks taken from an input at the moment a write is accepted. The count is clamped into parameter bounds, and a flag reports when clamping happened. The line can run as a push-pull output or as an open-drain output: in open-drain mode a high is produced by releasing the output enable, never by driving. The block remembers whether the receiver has been enabled. Commands are taken only while the block is idle, and a single-cycle done pulse marks the end of every sequence.

Top module: `swire_host_tx`

## Requirements
- R1: After reset the line is driven low (push-pull: `line_oe`=1, `line_o`=0), `busy`, `done` and `err` are 0, and the link counts as disabled.
- R2: An enable command (`cmd_op`=1) drives the line high from the accept edge for `EN_HOLD_CYC` cycles, after which the link is enabled and the line stays high.
- R3: A disable command (`cmd_op`=2) drives the line low from the accept edge for `DIS_HOLD_CYC` cycles, after which the link is disabled and the line stays low.
- R4: A write command (`cmd_op`=0) on an enabled link emits bit slots of P cycles each, beginning at the accept edge: low, high (wake), low, high (calibration), low (start), 5 address bits MSB first, 8 data bits MSB first.
- R5: The write frame ends with 5 high slots of standby, so the whole frame takes 23·P cycles, and the line then stays high.
- R6: P is `bit_div` clamped to [`DIV_MIN`, `DIV_MAX`]. `div_clamped` is set on acceptance of a write whose `bit_div` was out of range, and is cleared on acceptance of one that was in range.
- R7: While `busy` is 1, `cmd_valid` is ignored: the line waveform, `done` and `err` are unaffected.
- R8: A write command while the link is disabled raises `err` for one cycle, leaves `busy` at 0, and does not toggle the line.
- R9: In open-drain mode (`od_mode`=1) `line_o` is 0 and `line_oe` is the inverse of the line level. In push-pull mode `line_oe` is 1 and `line_o` is the level.
- R10: `done` is a one-cycle pulse in the cycle after the last slot or hold cycle, with `busy` already 0.
- R11: The reserved op code (`cmd_op`=3) is rejected with a one-cycle `err` pulse and no line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 write, 1 enable, 2 disable, 3 reserved |
| cmd_addr | input | ADDR_W | Receiver register address |
| cmd_data | input | DATA_W | Byte to write |
| bit_div | input | DIV_W | Requested bit time in clock cycles |
| od_mode | input | 1 | 1 selects open-drain signalling |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | One-cycle pulse on a rejected command |
| div_clamped | output | 1 | Bit time of the last accepted write was clamped |
| line_o | output | 1 | Output data toward the pad |
| line_oe | output | 1 | Output enable toward the pad |

## Verification
The hardest case to reach is a command that arrives in the middle of a frame. It has to be dropped silently, and the frame it overlaps must not change by even one cycle. The stimulus launches a slow, clamped-high write. Ten cycles later, while the wake pulse is still on the line, it pulses a disable request. The scoreboard then checks every cycle of the frame that is already queued, including `err`. Clamping at both bounds and the open-drain mapping also get frames of their own, so that each slot length and each drive level is compared cycle by cycle.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_DISABLE = 2'd2,
        OP_RSVD    = 2'd3
    } swire_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_HOLD  = 2'd2
    } swire_st_e;

endpackage

// File: rtl/swire_period_clamp.sv
module swire_period_clamp #(
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 8,
    parameter int DIV_MAX = 50000
) (
    input  logic [DIV_W-1:0] raw_div,
    output logic [DIV_W-1:0] eff_div,
    output logic             out_of_range
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

    always_comb begin
        if (raw_div < LO) begin
            eff_div      = LO;
            out_of_range = 1'b1;
        end else if (raw_div > HI) begin
            eff_div      = HI;
            out_of_range = 1'b1;
        end else begin
            eff_div      = raw_div;
            out_of_range = 1'b0;
        end
    end
endmodule

// File: rtl/swire_pad_map.sv
module swire_pad_map (
    input  logic level,
    input  logic od_mode,
    output logic pad_o,
    output logic pad_oe
);
    // open-drain: drive low only, release for high
    always_comb begin
        if (od_mode) begin
            pad_o  = 1'b0;
            pad_oe = ~level;
        end else begin
            pad_o  = level;
            pad_oe = 1'b1;
        end
    end
endmodule

// File: rtl/swire_host_tx.sv
module swire_host_tx #(
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 8,
    parameter int STBY_BITS    = 5,
    parameter int DIV_W        = 16,
    parameter int DIV_MIN      = 8,
    parameter int DIV_MAX      = 50000,
    parameter int EN_HOLD_CYC  = 220000,
    parameter int DIS_HOLD_CYC = 2100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              od_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              div_clamped,
    output logic              line_o,
    output logic              line_oe
);
    import swire_pkg::*;

    localparam int PRE_BITS   = 5;  // wake L/H, calibration L/H, start L
    localparam int FRAME_BITS = PRE_BITS + ADDR_W + DATA_W + STBY_BITS;
    localparam int SLOT_W     = $clog2(FRAME_BITS);
    localparam int MAX_A      = (EN_HOLD_CYC > DIS_HOLD_CYC) ? EN_HOLD_CYC : DIS_HOLD_CYC;
    localparam int MAXC       = (MAX_A > DIV_MAX) ? MAX_A : DIV_MAX;
    localparam int CNT_W      = $clog2(MAXC + 1);

    typedef struct packed {
        swire_st_e              st;
        logic [CNT_W-1:0]       cnt;
        logic [SLOT_W-1:0]      slot;
        logic [FRAME_BITS-1:0]  sh;
        logic [CNT_W-1:0]       per;
        logic                   lvl;
        logic                   link;
        logic                   tgt;
        logic                   done;
        logic                   err;
        logic                   clamp;
    } regs_t;

    regs_t r_d, r_q;

    logic [DIV_W-1:0]      eff_div;
    logic                  div_oor;
    logic [FRAME_BITS-1:0] frame_vec;
    swire_op_e             op;

    swire_period_clamp #(
        .DIV_W  (DIV_W),
        .DIV_MIN(DIV_MIN),
        .DIV_MAX(DIV_MAX)
    ) u_clamp (
        .raw_div     (bit_div),
        .eff_div     (eff_div),
        .out_of_range(div_oor)
    );

    swire_pad_map u_pad (
        .level  (r_q.lvl),
        .od_mode(od_mode),
        .pad_o  (line_o),
        .pad_oe (line_oe)
    );

    assign op        = swire_op_e'(cmd_op);
    assign frame_vec = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, cmd_addr, cmd_data, {STBY_BITS{1'b1}}};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_WRITE: begin
                            if (r_q.link) begin
                                r_d.st    = ST_FRAME;
                                r_d.sh    = frame_vec;
                                r_d.slot  = SLOT_W'(FRAME_BITS - 1);
                                r_d.per   = CNT_W'(eff_div);
                                r_d.cnt   = CNT_W'(eff_div) - 1'b1;
                                r_d.lvl   = frame_vec[FRAME_BITS-1];
                                r_d.clamp = div_oor;
                            end else begin
                                r_d.err = 1'b1;
                            end
                        end
                        OP_ENABLE: begin
                            r_d.st  = ST_HOLD;
                            r_d.cnt = CNT_W'(EN_HOLD_CYC - 1);
                            r_d.lvl = 1'b1;
                            r_d.tgt = 1'b1;
                        end
                        OP_DISABLE: begin
                            r_d.st  = ST_HOLD;
                            r_d.cnt = CNT_W'(DIS_HOLD_CYC - 1);
                            r_d.lvl = 1'b0;
                            r_d.tgt = 1'b0;
                        end
                        default: r_d.err = 1'b1;
                    endcase
                end
            end
            ST_FRAME: begin
                if (r_q.cnt == '0) begin
                    if (r_q.slot == '0) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.lvl  = 1'b1;
                    end else begin
                        r_d.slot = r_q.slot - 1'b1;
                        r_d.sh   = r_q.sh << 1;
                        r_d.lvl  = r_q.sh[FRAME_BITS-2];
                        r_d.cnt  = r_q.per - 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.link = r_q.tgt;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign err         = r_q.err;
    assign div_clamped = r_q.clamp;

    // ---------------- assertions ----------------
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));

    p_frame_needs_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FRAME) |-> r_q.link);

    p_period_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FRAME) |-> (r_q.per >= CNT_W'(DIV_MIN) && r_q.per <= CNT_W'(DIV_MAX)));

    p_slot_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FRAME && r_q.cnt != '0) |=> $stable(r_q.lvl));

    p_standby_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FRAME && r_q.slot < SLOT_W'(STBY_BITS)) |-> r_q.lvl);

    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !err);

    p_od_no_drive_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> (!line_o && (line_oe == !r_q.lvl)));

    p_pp_always_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !od_mode |-> (line_oe && (line_o == r_q.lvl)));

endmodule

// File: tb/tb_swire_host_tx.sv
module tb_swire_host_tx;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int DIV_W   = 8;
    localparam int DMIN    = 3;
    localparam int DMAX    = 12;
    localparam int EN_H    = 40;
    localparam int DIS_H   = 90;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [DIV_W-1:0]  bit_div = 8'd4;
    logic              od_mode = 1'b0;
    logic busy, done, err, div_clamped, line_o, line_oe;

    always #2.5 clk = ~clk;

    swire_host_tx #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STBY_BITS(5), .DIV_W(DIV_W),
        .DIV_MIN(DMIN), .DIV_MAX(DMAX), .EN_HOLD_CYC(EN_H), .DIS_HOLD_CYC(DIS_H)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bit_div(bit_div),
        .od_mode(od_mode), .busy(busy), .done(done), .err(err),
        .div_clamped(div_clamped), .line_o(line_o), .line_oe(line_oe)
    );

    typedef struct {
        logic  lvl;
        logic  bsy;
        logic  dn;
        logic  er;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic link_b = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic logic wire_lvl();
        return od_mode ? ~line_oe : line_o;
    endfunction

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(wire_lvl() === e.lvl, e.tag, "line", int'(wire_lvl()), int'(e.lvl));
            check(busy === e.bsy, e.tag, "busy", int'(busy), int'(e.bsy));
            check(done === e.dn,  e.tag, "done", int'(done), int'(e.dn));
            check(err === e.er,   e.tag, "err",  int'(err),  int'(e.er));
            if (od_mode)
                check(line_o === 1'b0, "R9", "od line_o", int'(line_o), 0);
            else
                check(line_oe === 1'b1, "R9", "pp line_oe", int'(line_oe), 1);
        end
    end

    task automatic push(input logic l, input logic b, input logic d, input logic e,
                        input string tag);
        exp_t x;
        x.lvl = l; x.bsy = b; x.dn = d; x.er = e; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic issue(input logic [1:0] op, input logic [4:0] a, input logic [7:0] d,
                         input int div);
        while (busy || q.size() > 0) @(negedge clk);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; bit_div = DIV_W'(div);
        cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d, input int div,
                            input string tag);
        int   p;
        logic bits[23];
        bit   exp_clamp;
        issue(2'd0, a, d, div);
        if (!link_b) begin
            push(link_b, 0, 0, 1, "R8");
            for (int i = 0; i < 4; i++) push(link_b, 0, 0, 0, "R8");
            return;
        end
        p = (div < DMIN) ? DMIN : (div > DMAX) ? DMAX : div;
        exp_clamp = (div < DMIN) || (div > DMAX);
        bits[0] = 0; bits[1] = 1; bits[2] = 0; bits[3] = 1; bits[4] = 0;
        for (int i = 0; i < 5; i++) bits[5+i]  = a[4-i];
        for (int i = 0; i < 8; i++) bits[10+i] = d[7-i];
        for (int i = 18; i < 23; i++) bits[i] = 1;
        for (int s = 0; s < 23; s++)
            for (int c = 0; c < p; c++)
                push(bits[s], 1, 0, 0, (s < 18) ? tag : "R5");
        push(1, 0, 1, 0, "R5/R10");
        @(negedge clk);
        check(div_clamped === exp_clamp, "R6", "div_clamped", int'(div_clamped), int'(exp_clamp));
    endtask

    task automatic do_hold(input bit en);
        int n;
        string tag;
        n   = en ? EN_H : DIS_H;
        tag = en ? "R2" : "R3";
        issue(en ? 2'd1 : 2'd2, '0, '0, 4);
        for (int i = 0; i < n; i++) push(en, 1, 0, 0, tag);
        push(en, 0, 1, 0, tag);
        for (int i = 0; i < 3; i++) push(en, 0, 0, 0, tag);
        link_b = en;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(line_oe === 1'b1, "R1", "line_oe", int'(line_oe), 1);
        check(line_o === 1'b0,  "R1", "line_o",  int'(line_o), 0);
        check(busy === 1'b0,    "R1", "busy",    int'(busy), 0);
        check(done === 1'b0,    "R1", "done",    int'(done), 0);
        check(err === 1'b0,     "R1", "err",     int'(err), 0);

        do_write(5'h03, 8'h3C, 4, "R8");     // R8: rejected, link down
        drain();
        do_hold(1'b1);                        // R2
        drain();
        do_write(5'h15, 8'hA6, 4, "R4");     // R4/R5 in range
        drain();
        do_write(5'h1F, 8'h01, 1, "R6");     // R6 clamp low
        drain();
        do_write(5'h00, 8'hFF, 50, "R7");    // R6 clamp high, R7 injection
        repeat (10) @(negedge clk);
        cmd_op = 2'd2; cmd_valid = 1'b1;     // R7: must be ignored
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
        // R11 reserved op
        issue(2'd3, '0, '0, 4);
        push(1, 0, 0, 1, "R11");
        for (int i = 0; i < 3; i++) push(1, 0, 0, 0, "R11");
        drain();
        od_mode = 1'b1;                       // R9 open-drain frame
        repeat (2) @(negedge clk);
        do_write(5'h0A, 8'h5C, 5, "R9");
        drain();
        do_hold(1'b0);                        // R3
        drain();
        do_write(5'h11, 8'h22, 3, "R8");     // R8 again after disable
        drain();

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule